// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small 8-bit processor with a 16-bit address space. A 4-bit step counter, the opcode held in the instruction register and the carry and zero flags together address a control store. The store returns one microword per step. The decoder turns that microword into control strobes: a read-bus source, a write-bus destination, a memory address source, program counter and stack pointer actions, a step-counter clear and a 4-bit ALU operation code. The datapath registers, the ALU and the memories sit outside the block and act on these strobes.

Each instruction starts with the same fetch step. Its later steps run until a step asks for a clear of the step counter, with or without a program counter advance. The flags are part of the control-store address. A conditional jump therefore has one precomputed sequence for each flag pattern, and no separate branch comparator is needed. The microword is held as two halves. One half carries the bus selects and the other carries the address source, the counter action and the ALU code. Every opcode the store does not define runs as a no-operation.

Top module: `useq_ctrl`

## Requirements
- R1: At most one bit of `rd_oe_o` and at most one bit of `wr_le_o` is set in any cycle. Read bit order: 0 register group, 1 data register, 2 ALU temp, 3 PC low, 4 PC high, 5 RAM, 6 input port, 7 program memory. Write bit order: 0 instruction register, 1 address low, 2 address high, 3 PC low, 4 PC high, 5 ALU, 6 RAM, 7 output register, 8 data register, 9 register group. `addr_sel_o` is 0 for PC, 1 for the memory address register and 2 for SP.
- R2: While `rst_n` is low the step is 0 and the fetch strobes are driven, and this holds across clocks. A reset in the middle of a sequence returns the step to 0 at once.
- R3: Step 0 of every instruction is the fetch: read program memory, write the instruction register, address source PC, no counter action and ALU code 0. This holds for every opcode and flag value.
- R4: An undefined opcode runs fetch and then one step that clears the step counter and advances PC.
- R5: HALT (0xFF) runs fetch and then a clear without a PC advance, so it repeats with PC unchanged.
- R6: Register moves run as follows. 0x80–0x8F: register to register. 0x10–0x13: input port to register. 0x14–0x17: register to output register. Each of these is followed by a clear with PC advance. Immediates run as follows. 0x24–0x27: PC advance, then program memory to register. 0x02: PC advance, then program memory to output register. Each of these is followed by a clear with PC advance.
- R7: ALU ops first send a register to the ALU with a code. INC 0x18–0x1B uses code 0011 and ADD 0x90–0x97 uses code 1001. Both then send the ALU temp to the register group and clear with PC advance. CMP 0xE0–0xE7 uses code 0110 and then clears with PC advance, with no write-back.
- R8: Absolute load 0x5C–0x5F and absolute store 0x60–0x63 run these steps: PC advance; program memory to address low; PC advance; program memory to address high; one transfer between RAM and the register group with address source 1; clear with PC advance.
- R9: JMP (0xF0), whatever the flags, runs these steps: PC advance; program memory to data register; PC advance; program memory to PC high; data register to PC low; clear without PC advance.
- R10: A conditional jump (0xF8–0xFD) takes the R9 sequence when its condition holds. 0xF8 needs C=1 and Z=1. 0xF9 needs not both set. 0xFA needs C=1 and Z=0. 0xFB needs C=1. 0xFC needs C=0 and Z=0. 0xFD needs C equal to Z. When the condition fails, the sequence is two PC advances and then a clear with PC advance.
- R11: PUSH (0x64–0x67) writes the register group to RAM at SP, raises SP, then clears with PC advance. POP (0x68–0x6B) lowers SP, reads RAM at SP into the register group, then clears with PC advance.
- R12: CALL (0xF1) runs these steps: PC advance; program memory to data register; PC advance; PC low to RAM at SP; raise SP; PC high to RAM at SP; raise SP; program memory to PC high; data register to PC low; clear without PC advance. RET (0xF2) runs these steps: lower SP; RAM at SP to PC high; lower SP; RAM at SP to PC low; clear with PC advance.
- R13: The step advances by one each clock unless a clear is strobed. After a clear it is 0. It never passes 15 without a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 8 | Opcode from the instruction register |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| step_o | output | 4 | Current micro-step |
| rd_oe_o | output | 8 | One-hot read-bus source strobes |
| wr_le_o | output | 10 | One-hot write-bus destination strobes |
| addr_sel_o | output | 2 | Memory address source |
| pc_inc_o | output | 1 | Advance program counter |
| sp_inc_o | output | 1 | Raise stack pointer |
| sp_dec_o | output | 1 | Lower stack pointer |
| step_clr_o | output | 1 | Clear step counter |
| alu_op_o | output | 4 | ALU operation code |

## Verification
The reference model builds the expected microword sequence for each instruction and compares all strobes and the step number on every clock. Every conditional jump runs under all four flag patterns, which separates the six conditions from one another and the taken path from the fall-through path. JMP runs with opposite flag values to show that it ignores them. Undefined opcodes from several corners of the code space show the no-operation default. HALT runs twice in a row, and a reset part-way through CALL shows the abort path. Per instruction, the model also sums the PC advances, the SP moves and the PC loads, and checks those totals.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int OP_W   = 8;
    localparam int STEP_W = 4;
    localparam int ALU_W  = 4;
    localparam int NRD    = 8;
    localparam int NWR    = 10;

    localparam int RDB_PMEM = 7;
    localparam int WRB_IR   = 0;

    typedef enum logic [3:0] {
        RD_NONE, RD_REG, RD_DREG, RD_TEMP, RD_PCL, RD_PCH, RD_RAM, RD_INP, RD_PMEM
    } rd_e;

    typedef enum logic [3:0] {
        WR_NONE, WR_IR, WR_MAL, WR_MAH, WR_PCL, WR_PCH, WR_ALU, WR_RAM,
        WR_OUTR, WR_DREG, WR_REG
    } wr_e;

    typedef enum logic [1:0] {AS_PC, AS_MA, AS_SP} as_e;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_PC_INC, ACT_SP_INC, ACT_SP_DEC, ACT_CLR, ACT_CLR_PC
    } act_e;

    localparam logic [ALU_W-1:0] ALU_NOP = 4'b0000;
    localparam logic [ALU_W-1:0] ALU_INC = 4'b0011;
    localparam logic [ALU_W-1:0] ALU_ADD = 4'b1001;
    localparam logic [ALU_W-1:0] ALU_SUB = 4'b0110;

    // First control-store half: bus selects
    typedef struct packed {
        rd_e rd;
        wr_e wr;
    } uhalf_a_t;

    // Second control-store half: addressing, sequencing and ALU
    typedef struct packed {
        as_e              as;
        act_e             act;
        logic [ALU_W-1:0] alu;
    } uhalf_b_t;

    typedef struct packed {
        uhalf_a_t a;
        uhalf_b_t b;
    } uword_t;

    typedef enum logic [4:0] {
        C_NOP, C_HALT, C_MOVRR, C_IN, C_OUTR, C_MOVI, C_OUTI, C_INC, C_ADD,
        C_CMP, C_LDA, C_STA, C_JMP, C_JCC, C_PUSH, C_POP, C_CALL, C_RET
    } cls_e;

    function automatic uword_t mk(input rd_e rd, input wr_e wr, input as_e as,
                                  input act_e act, input logic [ALU_W-1:0] alu);
        uword_t w;
        w.a.rd  = rd;
        w.a.wr  = wr;
        w.b.as  = as;
        w.b.act = act;
        w.b.alu = alu;
        return w;
    endfunction

    function automatic uword_t xf(input rd_e rd, input wr_e wr, input as_e as);
        return mk(rd, wr, as, ACT_NONE, ALU_NOP);
    endfunction

    function automatic uword_t ct(input act_e act);
        return mk(RD_NONE, WR_NONE, AS_PC, act, ALU_NOP);
    endfunction

    function automatic cls_e classify(input logic [OP_W-1:0] op);
        cls_e k;
        k = C_NOP;
        if (op == 8'hFF)                      k = C_HALT;
        else if (op == 8'h02)                 k = C_OUTI;
        else if (op inside {[8'h10:8'h13]})   k = C_IN;
        else if (op inside {[8'h14:8'h17]})   k = C_OUTR;
        else if (op inside {[8'h18:8'h1B]})   k = C_INC;
        else if (op inside {[8'h24:8'h27]})   k = C_MOVI;
        else if (op inside {[8'h5C:8'h5F]})   k = C_LDA;
        else if (op inside {[8'h60:8'h63]})   k = C_STA;
        else if (op inside {[8'h64:8'h67]})   k = C_PUSH;
        else if (op inside {[8'h68:8'h6B]})   k = C_POP;
        else if (op inside {[8'h80:8'h8F]})   k = C_MOVRR;
        else if (op inside {[8'h90:8'h97]})   k = C_ADD;
        else if (op inside {[8'hE0:8'hE7]})   k = C_CMP;
        else if (op == 8'hF0)                 k = C_JMP;
        else if (op == 8'hF1)                 k = C_CALL;
        else if (op == 8'hF2)                 k = C_RET;
        else if (op inside {[8'hF8:8'hFD]})   k = C_JCC;
        return k;
    endfunction

    // Branch condition selected by the low opcode bits of 0xF8..0xFD
    function automatic logic cond_met(input logic [2:0] sel, input logic c, input logic z);
        logic r;
        case (sel)
            3'd0:    r = c & z;
            3'd1:    r = ~(c & z);
            3'd2:    r = c & ~z;
            3'd3:    r = c;
            3'd4:    r = ~c & ~z;
            3'd5:    r = ~(c ^ z);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    // Control store: address is {flags, opcode, step}
    function automatic uword_t ucode_word(input logic [OP_W-1:0] op, input logic c,
                                          input logic z, input logic [STEP_W-1:0] step);
        uword_t w;
        cls_e   k;
        logic   jt;
        k  = classify(op);
        jt = (k == C_JMP) || ((k == C_JCC) && cond_met(op[2:0], c, z));
        w  = ct(ACT_CLR);
        if (step == '0) begin
            w = xf(RD_PMEM, WR_IR, AS_PC);
        end else begin
            case (k)
                C_HALT: w = ct(ACT_CLR);
                C_MOVRR, C_IN, C_OUTR: begin
                    case (step)
                        4'd1: begin
                            if (k == C_MOVRR)   w = xf(RD_REG, WR_REG, AS_PC);
                            else if (k == C_IN) w = xf(RD_INP, WR_REG, AS_PC);
                            else                w = xf(RD_REG, WR_OUTR, AS_PC);
                        end
                        default: w = ct(ACT_CLR_PC);
                    endcase
                end
                C_MOVI, C_OUTI: begin
                    case (step)
                        4'd1: w = ct(ACT_PC_INC);
                        4'd2: w = xf(RD_PMEM, (k == C_MOVI) ? WR_REG : WR_OUTR, AS_PC);
                        default: w = ct(ACT_CLR_PC);
                    endcase
                end
                C_INC, C_ADD: begin
                    case (step)
                        4'd1: w = mk(RD_REG, WR_ALU, AS_PC, ACT_NONE,
                                     (k == C_INC) ? ALU_INC : ALU_ADD);
                        4'd2: w = xf(RD_TEMP, WR_REG, AS_PC);
                        default: w = ct(ACT_CLR_PC);
                    endcase
                end
                C_CMP: begin
                    case (step)
                        4'd1: w = mk(RD_REG, WR_ALU, AS_PC, ACT_NONE, ALU_SUB);
                        default: w = ct(ACT_CLR_PC);
                    endcase
                end
                C_LDA, C_STA: begin
                    case (step)
                        4'd1, 4'd3: w = ct(ACT_PC_INC);
                        4'd2: w = xf(RD_PMEM, WR_MAL, AS_PC);
                        4'd4: w = xf(RD_PMEM, WR_MAH, AS_PC);
                        4'd5: begin
                            if (k == C_LDA) w = xf(RD_RAM, WR_REG, AS_MA);
                            else            w = xf(RD_REG, WR_RAM, AS_MA);
                        end
                        default: w = ct(ACT_CLR_PC);
                    endcase
                end
                C_JMP, C_JCC: begin
                    if (jt) begin
                        case (step)
                            4'd1, 4'd3: w = ct(ACT_PC_INC);
                            4'd2: w = xf(RD_PMEM, WR_DREG, AS_PC);
                            4'd4: w = xf(RD_PMEM, WR_PCH, AS_PC);
                            4'd5: w = xf(RD_DREG, WR_PCL, AS_PC);
                            default: w = ct(ACT_CLR);
                        endcase
                    end else begin
                        case (step)
                            4'd1, 4'd2: w = ct(ACT_PC_INC);
                            default: w = ct(ACT_CLR_PC);
                        endcase
                    end
                end
                C_PUSH: begin
                    case (step)
                        4'd1: w = xf(RD_REG, WR_RAM, AS_SP);
                        4'd2: w = ct(ACT_SP_INC);
                        default: w = ct(ACT_CLR_PC);
                    endcase
                end
                C_POP: begin
                    case (step)
                        4'd1: w = ct(ACT_SP_DEC);
                        4'd2: w = xf(RD_RAM, WR_REG, AS_SP);
                        default: w = ct(ACT_CLR_PC);
                    endcase
                end
                C_CALL: begin
                    case (step)
                        4'd1, 4'd3: w = ct(ACT_PC_INC);
                        4'd2: w = xf(RD_PMEM, WR_DREG, AS_PC);
                        4'd4: w = xf(RD_PCL, WR_RAM, AS_SP);
                        4'd5, 4'd7: w = ct(ACT_SP_INC);
                        4'd6: w = xf(RD_PCH, WR_RAM, AS_SP);
                        4'd8: w = xf(RD_PMEM, WR_PCH, AS_PC);
                        4'd9: w = xf(RD_DREG, WR_PCL, AS_PC);
                        default: w = ct(ACT_CLR);
                    endcase
                end
                C_RET: begin
                    case (step)
                        4'd1, 4'd3: w = ct(ACT_SP_DEC);
                        4'd2: w = xf(RD_RAM, WR_PCH, AS_SP);
                        4'd4: w = xf(RD_RAM, WR_PCL, AS_SP);
                        default: w = ct(ACT_CLR_PC);
                    endcase
                end
                default: w = ct(ACT_CLR_PC);
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/useq_stepper.sv
module useq_stepper #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    output logic [STEP_W-1:0] step_o
);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.step = '0;
        else       st_d.step = st_q.step + STEP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step_o = st_q.step;

    AST_STEP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step == {STEP_W{1'b1}}) |-> clr_i); // R13

endmodule

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic              flag_c_i,
    input  logic              flag_z_i,
    input  logic [STEP_W-1:0] step_i,
    output uhalf_a_t          half_a_o,
    output uhalf_b_t          half_b_o
);

    uword_t word;

    always_comb begin
        word     = ucode_word(op_i, flag_c_i, flag_z_i, step_i);
        half_a_o = word.a;
        half_b_o = word.b;
    end

endmodule

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
(
    input  uhalf_a_t          half_a_i,
    input  uhalf_b_t          half_b_i,
    output logic [NRD-1:0]    rd_oe_o,
    output logic [NWR-1:0]    wr_le_o,
    output logic [1:0]        addr_sel_o,
    output logic              pc_inc_o,
    output logic              sp_inc_o,
    output logic              sp_dec_o,
    output logic              step_clr_o,
    output logic [ALU_W-1:0]  alu_op_o
);

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_oe_o[g] = (4'(half_a_i.rd) == 4'(g + 1));
    end

    for (genvar g = 0; g < NWR; g++) begin : g_wr
        assign wr_le_o[g] = (4'(half_a_i.wr) == 4'(g + 1));
    end

    always_comb begin
        addr_sel_o = half_b_i.as;
        alu_op_o   = half_b_i.alu;
        pc_inc_o   = (half_b_i.act == ACT_PC_INC) || (half_b_i.act == ACT_CLR_PC);
        sp_inc_o   = (half_b_i.act == ACT_SP_INC);
        sp_dec_o   = (half_b_i.act == ACT_SP_DEC);
        step_clr_o = (half_b_i.act == ACT_CLR) || (half_b_i.act == ACT_CLR_PC);
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic              flag_c_i,
    input  logic              flag_z_i,
    output logic [STEP_W-1:0] step_o,
    output logic [NRD-1:0]    rd_oe_o,
    output logic [NWR-1:0]    wr_le_o,
    output logic [1:0]        addr_sel_o,
    output logic              pc_inc_o,
    output logic              sp_inc_o,
    output logic              sp_dec_o,
    output logic              step_clr_o,
    output logic [ALU_W-1:0]  alu_op_o
);

    uhalf_a_t half_a;
    uhalf_b_t half_b;

    useq_stepper #(.STEP_W(STEP_W)) i_stepper (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (step_clr_o),
        .step_o (step_o)
    );

    useq_store i_store (
        .op_i     (op_i),
        .flag_c_i (flag_c_i),
        .flag_z_i (flag_z_i),
        .step_i   (step_o),
        .half_a_o (half_a),
        .half_b_o (half_b)
    );

    useq_decode i_decode (
        .half_a_i   (half_a),
        .half_b_i   (half_b),
        .rd_oe_o    (rd_oe_o),
        .wr_le_o    (wr_le_o),
        .addr_sel_o (addr_sel_o),
        .pc_inc_o   (pc_inc_o),
        .sp_inc_o   (sp_inc_o),
        .sp_dec_o   (sp_dec_o),
        .step_clr_o (step_clr_o),
        .alu_op_o   (alu_op_o)
    );

    AST_FETCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == '0) |-> (rd_oe_o[RDB_PMEM] && wr_le_o[WRB_IR] && !pc_inc_o && !step_clr_o)); // R3

    AST_RESTART_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        step_clr_o |=> (step_o == '0)); // R13

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 8'hFF) && (step_o == STEP_W'(1))) |-> (step_clr_o && !pc_inc_o)); // R5

    AST_SP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_inc_o || sp_dec_o) |-> (!pc_inc_o && !step_clr_o && (wr_le_o == '0))); // R11

endmodule

// File: tb/test_useq_ctrl.sv
`timescale 1ns/1ps
module test_useq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_i = 8'h00;
    logic        flag_c_i = 1'b0;
    logic        flag_z_i = 1'b0;
    logic [3:0]  step_o;
    logic [7:0]  rd_oe_o;
    logic [9:0]  wr_le_o;
    logic [1:0]  addr_sel_o;
    logic        pc_inc_o, sp_inc_o, sp_dec_o, step_clr_o;
    logic [3:0]  alu_op_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    useq_ctrl i_useq_ctrl (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .flag_c_i(flag_c_i), .flag_z_i(flag_z_i),
        .step_o(step_o), .rd_oe_o(rd_oe_o), .wr_le_o(wr_le_o), .addr_sel_o(addr_sel_o),
        .pc_inc_o(pc_inc_o), .sp_inc_o(sp_inc_o), .sp_dec_o(sp_dec_o),
        .step_clr_o(step_clr_o), .alu_op_o(alu_op_o)
    );

    // read codes (bit index + 1)
    localparam int R_REG = 1, R_DREG = 2, R_TEMP = 3, R_PCL = 4, R_PCH = 5, R_RAM = 6,
                   R_INP = 7, R_PMEM = 8;
    // write codes (bit index + 1)
    localparam int W_IR = 1, W_MAL = 2, W_MAH = 3, W_PCL = 4, W_PCH = 5, W_ALU = 6,
                   W_RAM = 7, W_OUTR = 8, W_DREG = 9, W_REG = 10;
    localparam int A_PC = 0, A_MA = 1, A_SP = 2;

    logic [17:0] exp_q[$];

    function automatic logic [17:0] ew(int rd, int wr, int as, int pc, int si, int sd,
                                       int cl, int alu);
        return {rd[3:0], wr[3:0], as[1:0], pc[0], si[0], sd[0], cl[0], alu[3:0]};
    endfunction

    function automatic logic [17:0] seen();
        int rd = 0;
        int wr = 0;
        for (int i = 0; i < 8; i++) if (rd_oe_o[i]) rd = i + 1;
        for (int i = 0; i < 10; i++) if (wr_le_o[i]) wr = i + 1;
        return {rd[3:0], wr[3:0], addr_sel_o, pc_inc_o, sp_inc_o, sp_dec_o, step_clr_o, alu_op_o};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(int rd, int wr, int as);
        exp_q.push_back(ew(rd, wr, as, 0, 0, 0, 0, 0));
    endtask
    task automatic pc_step();   exp_q.push_back(ew(0, 0, 0, 1, 0, 0, 0, 0)); endtask
    task automatic spi_step();  exp_q.push_back(ew(0, 0, 0, 0, 1, 0, 0, 0)); endtask
    task automatic spd_step();  exp_q.push_back(ew(0, 0, 0, 0, 0, 1, 0, 0)); endtask
    task automatic end_pc();    exp_q.push_back(ew(0, 0, 0, 1, 0, 0, 1, 0)); endtask
    task automatic end_hold();  exp_q.push_back(ew(0, 0, 0, 0, 0, 0, 1, 0)); endtask

    function automatic bit branch_ok(logic [7:0] op, bit c, bit z);
        case (op)
            8'hF8: return c && z;
            8'hF9: return !(c && z);
            8'hFA: return c && !z;
            8'hFB: return c;
            8'hFC: return !c && !z;
            8'hFD: return c == z;
            default: return 1'b0;
        endcase
    endfunction

    // Reference model: expected steps after fetch, plus requirement tag and totals
    task automatic model(input logic [7:0] op, input bit c, input bit z, output string tag,
                         output int pcs, output int spn, output int loads);
        exp_q.delete();
        pcs = 1; spn = 0; loads = 0;
        if (op == 8'hFF) begin
            tag = "R5"; pcs = 0; end_hold();
        end else if (op >= 8'h80 && op <= 8'h8F) begin
            tag = "R6"; put(R_REG, W_REG, A_PC); end_pc();
        end else if (op >= 8'h10 && op <= 8'h13) begin
            tag = "R6"; put(R_INP, W_REG, A_PC); end_pc();
        end else if (op >= 8'h14 && op <= 8'h17) begin
            tag = "R6"; put(R_REG, W_OUTR, A_PC); end_pc();
        end else if ((op >= 8'h24 && op <= 8'h27) || op == 8'h02) begin
            tag = "R6"; pcs = 2; pc_step();
            put(R_PMEM, (op == 8'h02) ? W_OUTR : W_REG, A_PC); end_pc();
        end else if ((op >= 8'h18 && op <= 8'h1B) || (op >= 8'h90 && op <= 8'h97)) begin
            tag = "R7";
            exp_q.push_back(ew(R_REG, W_ALU, A_PC, 0, 0, 0, 0, (op < 8'h90) ? 3 : 9));
            put(R_TEMP, W_REG, A_PC); end_pc();
        end else if (op >= 8'hE0 && op <= 8'hE7) begin
            tag = "R7";
            exp_q.push_back(ew(R_REG, W_ALU, A_PC, 0, 0, 0, 0, 6)); end_pc();
        end else if (op >= 8'h5C && op <= 8'h63) begin
            tag = "R8"; pcs = 3;
            pc_step(); put(R_PMEM, W_MAL, A_PC); pc_step(); put(R_PMEM, W_MAH, A_PC);
            if (op <= 8'h5F) put(R_RAM, W_REG, A_MA); else put(R_REG, W_RAM, A_MA);
            end_pc();
        end else if (op == 8'hF0 || (op >= 8'hF8 && op <= 8'hFD && branch_ok(op, c, z))) begin
            tag = (op == 8'hF0) ? "R9" : "R10"; pcs = 2; loads = 2;
            pc_step(); put(R_PMEM, W_DREG, A_PC); pc_step(); put(R_PMEM, W_PCH, A_PC);
            put(R_DREG, W_PCL, A_PC); end_hold();
        end else if (op >= 8'hF8 && op <= 8'hFD) begin
            tag = "R10"; pcs = 3; pc_step(); pc_step(); end_pc();
        end else if (op >= 8'h64 && op <= 8'h67) begin
            tag = "R11"; spn = 1; put(R_REG, W_RAM, A_SP); spi_step(); end_pc();
        end else if (op >= 8'h68 && op <= 8'h6B) begin
            tag = "R11"; spn = -1; spd_step(); put(R_RAM, W_REG, A_SP); end_pc();
        end else if (op == 8'hF1) begin
            tag = "R12"; pcs = 2; spn = 2; loads = 2;
            pc_step(); put(R_PMEM, W_DREG, A_PC); pc_step();
            put(R_PCL, W_RAM, A_SP); spi_step(); put(R_PCH, W_RAM, A_SP); spi_step();
            put(R_PMEM, W_PCH, A_PC); put(R_DREG, W_PCL, A_PC); end_hold();
        end else if (op == 8'hF2) begin
            tag = "R12"; spn = -2; loads = 2;
            spd_step(); put(R_RAM, W_PCH, A_SP); spd_step(); put(R_RAM, W_PCL, A_SP); end_pc();
        end else begin
            tag = "R4"; end_pc();
        end
    endtask

    task automatic chk_fetch(input string why);
        chk(seen() == ew(R_PMEM, W_IR, A_PC, 0, 0, 0, 0, 0), "R3", {"fetch word ", why},
            seen(), ew(R_PMEM, W_IR, A_PC, 0, 0, 0, 0, 0));
    endtask

    // Called just after a falling edge with the step at 0
    task automatic run_instr(input logic [7:0] op, input bit c, input bit z);
        string tag;
        int pcs, spn, loads, n;
        int g_pc = 0, g_sp = 0, g_ld = 0;
        chk(step_o == 4'd0, "R13", "step at instruction start", step_o, 0);
        chk_fetch($sformatf("op %02h", op));
        op_i = op; flag_c_i = c; flag_z_i = z;
        model(op, c, z, tag, pcs, spn, loads);
        n = exp_q.size();
        for (int k = 1; k <= n; k++) begin
            logic [17:0] e;
            @(negedge clk);
            e = exp_q.pop_front();
            chk(step_o == 4'(k), "R13", $sformatf("step index op %02h", op), step_o, k);
            chk(seen() == e, tag, $sformatf("op %02h c%0d z%0d step %0d", op, c, z, k),
                seen(), e);
            chk(($countones(rd_oe_o) <= 1) && ($countones(wr_le_o) <= 1), "R1",
                "single strobe per bus", {rd_oe_o, wr_le_o}, 0);
            g_pc += pc_inc_o;
            g_sp += sp_inc_o - sp_dec_o;
            g_ld += wr_le_o[3] + wr_le_o[4];
        end
        chk(g_pc == pcs, tag, $sformatf("PC advances op %02h", op), g_pc, pcs);
        chk(g_sp == spn, tag, $sformatf("SP net op %02h", op), g_sp, spn);
        chk(g_ld == loads, tag, $sformatf("PC loads op %02h", op), g_ld, loads);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R2: reset holds the fetch step
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(step_o == 4'd0, "R2", "step in reset", step_o, 0);
            chk(seen() == ew(R_PMEM, W_IR, A_PC, 0, 0, 0, 0, 0), "R2", "fetch in reset",
                seen(), ew(R_PMEM, W_IR, A_PC, 0, 0, 0, 0, 0));
        end
        rst_n = 1'b1;

        // R4: undefined opcodes
        run_instr(8'h00, 0, 0);
        run_instr(8'h55, 1, 0);
        run_instr(8'hFE, 1, 1);
        run_instr(8'h98, 0, 1);
        run_instr(8'h01, 1, 1);
        // R5: HALT repeats
        run_instr(8'hFF, 0, 0);
        run_instr(8'hFF, 1, 1);
        // R6
        run_instr(8'h80, 0, 0);
        run_instr(8'h8F, 1, 1);
        run_instr(8'h12, 0, 0);
        run_instr(8'h15, 0, 0);
        run_instr(8'h25, 0, 0);
        run_instr(8'h02, 1, 0);
        // R7
        run_instr(8'h1A, 0, 0);
        run_instr(8'h93, 1, 1);
        run_instr(8'hE5, 0, 1);
        // R8
        run_instr(8'h5C, 0, 0);
        run_instr(8'h63, 1, 1);
        // R9: flags ignored
        run_instr(8'hF0, 0, 0);
        run_instr(8'hF0, 1, 0);
        run_instr(8'hF0, 1, 1);
        // R10: every condition under every flag pattern
        for (int o = 8'hF8; o <= 8'hFD; o++)
            for (int f = 0; f < 4; f++)
                run_instr(8'(o), f[1], f[0]);
        // R11
        run_instr(8'h64, 0, 0);
        run_instr(8'h6B, 1, 0);
        // R12
        run_instr(8'hF1, 0, 0);
        run_instr(8'hF2, 1, 1);

        // R2: reset part-way through CALL
        op_i = 8'hF1;
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk(step_o == 4'd3, "R2", "step before abort", step_o, 3);
        rst_n = 1'b0;
        #0.5;
        chk(step_o == 4'd0, "R2", "step right after reset edge", step_o, 0);
        chk(seen() == ew(R_PMEM, W_IR, A_PC, 0, 0, 0, 0, 0), "R2", "fetch after abort",
            seen(), ew(R_PMEM, W_IR, A_PC, 0, 0, 0, 0, 0));
        op_i = 8'h00;
        @(negedge clk);
        chk(step_o == 4'd0, "R2", "step held in reset", step_o, 0);
        rst_n = 1'b1;
        run_instr(8'h68, 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule